// File: doc/BRIEF.md
# Bus Master Transfer Sequencer

This block carries out one data transfer as bus master on an asynchronous, UNIBUS-style backplane. The local host has already won mastership and holds BBSY on its own. It then loads an 18-bit target address in two pieces and arms the sequencer with a transfer mode. That mode gives the direction and whether the transfer is a byte or a word. A read starts as soon as it is armed. A write waits in a pending state until the host loads the outgoing data word, and that load is what launches the transfer.

Once launched, the sequencer puts the address, the two cycle-type control lines and, for a write, the data on the bus. It lets them settle for a fixed number of clocks and then raises the master strobe (MSYN). It holds the strobe until the slave answers with SSYN. A read latches the slave's data on that answer. The sequencer then drops MSYN and keeps the lines driven until the slave drops SSYN, and after that it falls back to idle. If no answer arrives within a host-programmed number of clocks, the strobe is withdrawn and a timeout flag is raised. The host tracks progress through separate idle, busy and pending flags and a 3-bit state code.

Top module: `dma_master_seq`

## Requirements
- R1: After reset, st_idle is 1, st_state is 0, st_busy, st_pend and st_timeout are 0, and bus_msyn_o, bus_addr_oe and bus_data_oe are 0.
- R2: A mode load with host_wdata[0]=1 (write to slave) moves the sequencer to state 1 (armed), with st_pend=1 and nothing driven onto the bus. A later data load from state 1 starts the transfer. A mode load with host_wdata[0]=0 (read from slave) starts the transfer on the next cycle.
- R3: After a start, bus_addr_oe is 1 for exactly SETUP_CYC clocks before bus_msyn_o rises. During those clocks and the strobe, bus_c1_o equals the mode's host_wdata[0] and bus_c0_o equals its host_wdata[1].
- R4: bus_msyn_o stays high until SSYN is sampled high, and it goes low in the following cycle.
- R5: In a read, rd_data shows the bus_data_i value sampled in the cycle where SSYN is first seen.
- R6: After MSYN drops, the address (and, in a write, the data) stay driven until SSYN is sampled low. The sequencer then returns to idle.
- R7: bus_data_oe is 1 only during a write transfer, and bus_data_o then carries the loaded data word.
- R8: The state codes are idle=0, armed=1, setup=2, strobe=3, release=4. st_idle is set only in state 0, st_pend only in state 1, and st_busy only in states 2 to 4. At most one of the three flags is high.
- R9: If SSYN has not been seen after tmo_limit clocks of MSYN, MSYN drops, st_timeout is set and the sequencer returns to idle. st_timeout is cleared by the next start.
- R10: While a transfer is in progress (states 2 to 4), address and mode loads are ignored. A data load in state 0 starts nothing.
- R11: An address-high load places host_wdata[1:0] in address bits 17:16. An address-low load places host_wdata[15:0] in bits 15:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tmo_limit | input | TMO_W | Number of strobe clocks allowed before timeout |
| host_wdata | input | DW | Host write data for all loads |
| ld_addr_hi | input | 1 | Load address bits 17:16 |
| ld_addr_lo | input | 1 | Load address bits 15:0 |
| ld_mode | input | 1 | Arm: bit0 = write to slave, bit1 = byte |
| ld_data | input | 1 | Load outgoing data word (starts a write) |
| bus_ssyn_i | input | 1 | Slave acknowledge, active high |
| bus_data_i | input | DW | Data received from the bus |
| bus_addr_o | output | AW | Latched transfer address |
| bus_addr_oe | output | 1 | Enable address drivers onto the bus |
| bus_c1_o | output | 1 | Cycle type C1 (1 = write) |
| bus_c0_o | output | 1 | Cycle type C0 (1 = byte) |
| bus_data_o | output | DW | Outgoing data word |
| bus_data_oe | output | 1 | Enable data drivers onto the bus |
| bus_msyn_o | output | 1 | Master strobe, active high |
| rd_data | output | DW | Data captured by the last read |
| st_idle | output | 1 | Sequencer idle |
| st_busy | output | 1 | Transfer in progress |
| st_pend | output | 1 | Armed for a write, awaiting data |
| st_timeout | output | 1 | Last transfer timed out |
| st_state | output | 3 | State code |

## Verification
The assertions take for granted a well-behaved slave. It raises SSYN only while MSYN is high and lowers it only after MSYN has gone. They also assume tmo_limit is nonzero and does not change during a transfer. The stimulus meets these conditions because the bench models the slave on one clock phase. That slave counts MSYN clocks before answering and counts again before releasing. The bench sweeps answer delays from one clock up to beyond the timeout limit, with both directions, both widths and two release delays.

// File: rtl/dms_pkg.sv
package dms_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_ARMED  = 3'd1,
    ST_SETUP  = 3'd2,
    ST_STROBE = 3'd3,
    ST_HOLD   = 3'd4
  } dms_state_e;

  typedef struct packed {
    logic byte_op;
    logic to_slave;
  } dms_mode_t;

  // True when a 0-based count in its last allowed cycle; lim of 0 acts as 1.
  function automatic logic count_reached(input int unsigned cnt, input int unsigned lim);
    return (cnt + 1) >= lim;
  endfunction

  function automatic logic in_transfer(input dms_state_e s);
    return (s == ST_SETUP) || (s == ST_STROBE) || (s == ST_HOLD);
  endfunction

  function automatic logic cfg_open(input dms_state_e s);
    return (s == ST_IDLE) || (s == ST_ARMED);
  endfunction

endpackage

// File: rtl/dms_regs.sv
module dms_regs
  import dms_pkg::*;
#(
  parameter int unsigned AW = 18,
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          open_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          ld_hi_i,
  input  logic          ld_lo_i,
  input  logic          ld_mode_i,
  input  logic          ld_data_i,
  output logic [AW-1:0] addr_o,
  output dms_mode_t     mode_o,
  output logic [DW-1:0] wbuf_o
);
  localparam int unsigned HI_W = AW - DW;

  logic [HI_W-1:0] addr_hi_q;
  logic [DW-1:0]   addr_lo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_hi_q <= '0;
      addr_lo_q <= '0;
      mode_o    <= '0;
      wbuf_o    <= '0;
    end else if (open_i) begin
      if (ld_hi_i)   addr_hi_q <= wdata_i[HI_W-1:0];
      if (ld_lo_i)   addr_lo_q <= wdata_i;
      if (ld_mode_i) mode_o    <= '{byte_op: wdata_i[1], to_slave: wdata_i[0]};
      if (ld_data_i) wbuf_o    <= wdata_i;
    end
  end

  assign addr_o = {addr_hi_q, addr_lo_q};

endmodule

// File: rtl/dms_fsm.sv
module dms_fsm
  import dms_pkg::*;
#(
  parameter int unsigned SETUP_CYC = 2,
  parameter int unsigned TMO_W     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_mode_i,
  input  logic             mode_wr_i,
  input  logic             ld_data_i,
  input  logic             ssyn_i,
  input  logic [TMO_W-1:0] tmo_limit_i,
  output dms_state_e       state_o,
  output logic             ev_start_o,
  output logic             ev_ack_o,
  output logic             ev_tmo_o,
  output logic             ev_done_o,
  output logic             tmo_flag_o
);
  localparam int unsigned SW = (SETUP_CYC < 2) ? 1 : $clog2(SETUP_CYC + 1);

  dms_state_e       state_q, state_d;
  logic [SW-1:0]    scnt_q;
  logic [TMO_W-1:0] tcnt_q;

  assign ev_ack_o  = (state_q == ST_STROBE) && ssyn_i;
  assign ev_tmo_o  = (state_q == ST_STROBE) && !ssyn_i &&
                     count_reached(32'(tcnt_q), 32'(tmo_limit_i));
  assign ev_done_o = (state_q == ST_HOLD) && !ssyn_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE, ST_ARMED: begin
        if (ld_mode_i)
          state_d = mode_wr_i ? ST_ARMED : ST_SETUP;
        else if ((state_q == ST_ARMED) && ld_data_i)
          state_d = ST_SETUP;
      end
      ST_SETUP:  if (count_reached(32'(scnt_q), SETUP_CYC)) state_d = ST_STROBE;
      ST_STROBE: if (ev_ack_o || ev_tmo_o) state_d = ST_HOLD;
      ST_HOLD:   if (ev_done_o) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  assign ev_start_o = cfg_open(state_q) && (state_d == ST_SETUP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      scnt_q     <= '0;
      tcnt_q     <= '0;
      tmo_flag_o <= 1'b0;
    end else begin
      state_q <= state_d;
      scnt_q  <= (state_q == ST_SETUP)  ? scnt_q + 1'b1 : '0;
      tcnt_q  <= (state_q == ST_STROBE) ? tcnt_q + 1'b1 : '0;
      if (ev_start_o)    tmo_flag_o <= 1'b0;
      else if (ev_tmo_o) tmo_flag_o <= 1'b1;
    end
  end

  assign state_o = state_q;

endmodule

// File: rtl/dms_busif.sv
module dms_busif
  import dms_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  dms_state_e    state_i,
  input  dms_mode_t     mode_i,
  input  logic          ev_ack_i,
  input  logic [DW-1:0] wbuf_i,
  input  logic [DW-1:0] bus_data_i,
  output logic          addr_oe_o,
  output logic          data_oe_o,
  output logic          msyn_o,
  output logic          c1_o,
  output logic          c0_o,
  output logic [DW-1:0] data_o,
  output logic [DW-1:0] rd_data_o
);
  logic active;
  assign active    = in_transfer(state_i);
  assign addr_oe_o = active;
  assign data_oe_o = active && mode_i.to_slave;
  assign msyn_o    = (state_i == ST_STROBE);
  assign c1_o      = mode_i.to_slave;
  assign c0_o      = mode_i.byte_op;
  assign data_o    = wbuf_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        rd_data_o <= '0;
    else if (ev_ack_i && !mode_i.to_slave) rd_data_o <= bus_data_i;
  end

endmodule

// File: rtl/dma_master_seq.sv
module dma_master_seq
  import dms_pkg::*;
#(
  parameter int unsigned AW        = 18,
  parameter int unsigned DW        = 16,
  parameter int unsigned SETUP_CYC = 2,
  parameter int unsigned TMO_W     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TMO_W-1:0] tmo_limit,
  input  logic [DW-1:0]    host_wdata,
  input  logic             ld_addr_hi,
  input  logic             ld_addr_lo,
  input  logic             ld_mode,
  input  logic             ld_data,
  input  logic             bus_ssyn_i,
  input  logic [DW-1:0]    bus_data_i,
  output logic [AW-1:0]    bus_addr_o,
  output logic             bus_addr_oe,
  output logic             bus_c1_o,
  output logic             bus_c0_o,
  output logic [DW-1:0]    bus_data_o,
  output logic             bus_data_oe,
  output logic             bus_msyn_o,
  output logic [DW-1:0]    rd_data,
  output logic             st_idle,
  output logic             st_busy,
  output logic             st_pend,
  output logic             st_timeout,
  output logic [2:0]       st_state
);
  dms_state_e    state;
  dms_mode_t     mode;
  logic [DW-1:0] wbuf;
  logic          ev_start, ev_ack, ev_tmo, ev_done;

  dms_regs #(.AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .open_i(cfg_open(state)), .wdata_i(host_wdata),
    .ld_hi_i(ld_addr_hi), .ld_lo_i(ld_addr_lo), .ld_mode_i(ld_mode),
    .ld_data_i(ld_data), .addr_o(bus_addr_o), .mode_o(mode), .wbuf_o(wbuf)
  );

  dms_fsm #(.SETUP_CYC(SETUP_CYC), .TMO_W(TMO_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .ld_mode_i(ld_mode), .mode_wr_i(host_wdata[0]),
    .ld_data_i(ld_data), .ssyn_i(bus_ssyn_i), .tmo_limit_i(tmo_limit),
    .state_o(state), .ev_start_o(ev_start), .ev_ack_o(ev_ack),
    .ev_tmo_o(ev_tmo), .ev_done_o(ev_done), .tmo_flag_o(st_timeout)
  );

  dms_busif #(.DW(DW)) u_bus (
    .clk(clk), .rst_n(rst_n), .state_i(state), .mode_i(mode), .ev_ack_i(ev_ack),
    .wbuf_i(wbuf), .bus_data_i(bus_data_i), .addr_oe_o(bus_addr_oe),
    .data_oe_o(bus_data_oe), .msyn_o(bus_msyn_o), .c1_o(bus_c1_o),
    .c0_o(bus_c0_o), .data_o(bus_data_o), .rd_data_o(rd_data)
  );

  assign st_idle  = (state == ST_IDLE);
  assign st_pend  = (state == ST_ARMED);
  assign st_busy  = in_transfer(state);
  assign st_state = state;

endmodule

// File: rtl/dma_master_seq_chk.sv
module dma_master_seq_chk #(
  parameter int unsigned AW    = 18,
  parameter int unsigned TMO_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [TMO_W-1:0] tmo_limit,
  input logic             ssyn,
  input logic             msyn,
  input logic             addr_oe,
  input logic             data_oe,
  input logic             c1,
  input logic [AW-1:0]    addr,
  input logic             idle,
  input logic             busy,
  input logic             pend,
  input logic             tmo_flag,
  input logic             ev_tmo,
  input logic             ev_done
);
  // R9 input condition: the limit is nonzero
  a_r9_limit_nonzero: assert property (@(posedge clk) disable iff (!rst_n) tmo_limit != '0);
  // R2: armed state drives nothing
  a_r2_pend_quiet: assert property (@(posedge clk) disable iff (!rst_n) pend |-> !addr_oe && !msyn);
  // R3: address driven the cycle before the strobe rises
  a_r3_setup_addr: assert property (@(posedge clk) disable iff (!rst_n) $rose(msyn) |-> $past(addr_oe));
  a_r3_setup_data: assert property (@(posedge clk) disable iff (!rst_n) ($rose(msyn) && c1) |-> $past(data_oe));
  // R4: strobe held until acknowledge, dropped after it
  a_r4_msyn_hold: assert property (@(posedge clk) disable iff (!rst_n) (msyn && !ssyn && !ev_tmo) |=> msyn);
  a_r4_msyn_drop: assert property (@(posedge clk) disable iff (!rst_n) (msyn && ssyn) |=> !msyn);
  // R6: lines released only after acknowledge negates
  a_r6_release: assert property (@(posedge clk) disable iff (!rst_n) $fell(addr_oe) |-> !$past(ssyn));
  a_r6_done_idle: assert property (@(posedge clk) disable iff (!rst_n) ev_done |=> idle);
  // R7: data drivers only for writes
  a_r7_data_write: assert property (@(posedge clk) disable iff (!rst_n) data_oe |-> (c1 && addr_oe));
  // R8: status flags exclusive
  a_r8_flags: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({idle, busy, pend}));
  // R9: timeout withdraws strobe and sets flag
  a_r9_timeout: assert property (@(posedge clk) disable iff (!rst_n) ev_tmo |=> (!msyn && tmo_flag));
  // R10: address stable during a transfer
  a_r10_addr_stable: assert property (@(posedge clk) disable iff (!rst_n) (addr_oe && $past(addr_oe)) |-> $stable(addr));
endmodule

bind dma_master_seq dma_master_seq_chk #(.AW(AW), .TMO_W(TMO_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tmo_limit(tmo_limit), .ssyn(bus_ssyn_i),
  .msyn(bus_msyn_o), .addr_oe(bus_addr_oe), .data_oe(bus_data_oe),
  .c1(bus_c1_o), .addr(bus_addr_o), .idle(st_idle), .busy(st_busy),
  .pend(st_pend), .tmo_flag(st_timeout), .ev_tmo(ev_tmo), .ev_done(ev_done)
);

// File: tb/test_dma_master_seq.sv
module test_dma_master_seq;
  localparam int CLK_P = 10;
  localparam int SETUP = 2;
  localparam int LIM   = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  tmo_limit = 8'(LIM);
  logic [15:0] host_wdata = '0;
  logic        ld_addr_hi = 0, ld_addr_lo = 0, ld_mode = 0, ld_data = 0;
  logic        bus_ssyn_i = 0;
  logic [15:0] bus_data_i = '0;
  logic [17:0] bus_addr_o;
  logic        bus_addr_oe, bus_c1_o, bus_c0_o, bus_data_oe, bus_msyn_o;
  logic [15:0] bus_data_o, rd_data;
  logic        st_idle, st_busy, st_pend, st_timeout;
  logic [2:0]  st_state;

  int n_run = 0, n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  dma_master_seq i_dma_master_seq (
    .clk(clk), .rst_n(rst_n), .tmo_limit(tmo_limit), .host_wdata(host_wdata),
    .ld_addr_hi(ld_addr_hi), .ld_addr_lo(ld_addr_lo), .ld_mode(ld_mode),
    .ld_data(ld_data), .bus_ssyn_i(bus_ssyn_i), .bus_data_i(bus_data_i),
    .bus_addr_o(bus_addr_o), .bus_addr_oe(bus_addr_oe), .bus_c1_o(bus_c1_o),
    .bus_c0_o(bus_c0_o), .bus_data_o(bus_data_o), .bus_data_oe(bus_data_oe),
    .bus_msyn_o(bus_msyn_o), .rd_data(rd_data), .st_idle(st_idle),
    .st_busy(st_busy), .st_pend(st_pend), .st_timeout(st_timeout),
    .st_state(st_state)
  );

  task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] slave_word(input logic [17:0] a);
    return a[15:0] ^ 16'hA53C ^ {a[17:16], 14'h0};
  endfunction

  task automatic load_addr(input logic [17:0] a);
    @(negedge clk); host_wdata = {14'h0, a[17:16]}; ld_addr_hi = 1;
    @(negedge clk); ld_addr_hi = 0; host_wdata = a[15:0]; ld_addr_lo = 1;
    @(negedge clk); ld_addr_lo = 0;
  endtask

  task automatic run_xfer(input logic wr, input logic bt, input logic [17:0] a,
                          input logic [15:0] d, input int dly, input int rel,
                          input logic poke);
    int n_setup = 0, n_msyn = 0, hi = 0, lo = 0, guard = 0;
    int exp_msyn;
    logic [15:0] pat = slave_word(a);
    exp_msyn = (dly <= LIM) ? dly : LIM;
    load_addr(a);
    host_wdata = {14'h0, bt, wr}; ld_mode = 1;
    @(negedge clk); ld_mode = 0;
    if (wr) begin
      chk(st_state == 3'd1 && st_pend && !st_idle && !st_busy, "R2 armed", st_state, 1);
      chk(!bus_addr_oe && !bus_msyn_o, "R2 armed quiet", bus_addr_oe, 0);
      host_wdata = d; ld_data = 1;
      @(negedge clk); ld_data = 0;
    end
    chk(st_state == 3'd2 && st_busy, "R2 start/R8 setup code", st_state, 2);
    while (st_state != 3'd0 && guard < 200) begin
      ld_addr_lo = 0; ld_mode = 0;
      if (bus_addr_oe && !bus_msyn_o && n_msyn == 0) n_setup++;
      if (bus_msyn_o) begin
        n_msyn++;
        chk(bus_addr_oe && bus_addr_o == a, "R3 addr", bus_addr_o, a);
        chk(bus_c1_o == wr && bus_c0_o == bt, "R3 c1c0", {bus_c1_o, bus_c0_o}, {wr, bt});
        chk(bus_data_oe == wr, "R7 data oe", bus_data_oe, wr);
        if (wr) chk(bus_data_o == d, "R7 data", bus_data_o, d);
        if (poke && n_msyn == 1) begin
          host_wdata = ~a[15:0]; ld_addr_lo = 1; ld_mode = 1;
        end
      end
      if (!bus_msyn_o && bus_ssyn_i && n_msyn > 0)
        chk(bus_addr_oe && bus_data_oe == wr, "R6 hold lines", bus_addr_oe, 1);
      if (bus_msyn_o) begin
        hi++;
        if (hi == dly) begin bus_ssyn_i = 1; bus_data_i = pat; end
      end else if (bus_ssyn_i) begin
        lo++;
        if (lo > rel) bus_ssyn_i = 0;
      end
      @(negedge clk); guard++;
    end
    ld_addr_lo = 0; ld_mode = 0;
    chk(guard < 200, "R4 completes", guard, 0);
    chk(n_setup == SETUP, "R3 setup cycles", n_setup, SETUP);
    chk(n_msyn == exp_msyn, "R4/R9 strobe cycles", n_msyn, exp_msyn);
    chk(st_timeout == (dly > LIM), "R9 timeout flag", st_timeout, dly > LIM);
    if (!wr && dly <= LIM) chk(rd_data == pat, "R5 read data", rd_data, pat);
    chk(st_idle && !st_busy && !st_pend && !bus_addr_oe && !bus_msyn_o, "R6/R8 idle", st_state, 0);
    if (poke) chk(bus_addr_o == a && bus_c1_o == wr, "R10 loads ignored", bus_addr_o, a);
  endtask

  initial begin
    #(CLK_P * 100000);
    n_fail++; n_run++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(st_idle && st_state == 0 && !st_busy && !st_pend && !st_timeout, "R1 flags", st_state, 0);
    chk(!bus_msyn_o && !bus_addr_oe && !bus_data_oe, "R1 bus", bus_msyn_o, 0);
    rst_n = 1;
    @(negedge clk);
    // R11: address composition
    load_addr(18'h2_BEEF);
    chk(bus_addr_o == 18'h2_BEEF, "R11 addr", bus_addr_o, 18'h2_BEEF);
    // R10: data load in idle starts nothing
    host_wdata = 16'h1234; ld_data = 1;
    @(negedge clk); ld_data = 0;
    for (int k = 0; k < 4; k++) begin
      chk(st_idle && !bus_msyn_o && !bus_addr_oe, "R10 idle data load", st_state, 0);
      @(negedge clk);
    end
    for (int wr = 0; wr < 2; wr++)
      for (int bt = 0; bt < 2; bt++)
        for (int dly = 1; dly <= LIM + 2; dly++)
          for (int rel = 0; rel < 2; rel++) begin
            logic [17:0] a;
            a = 18'((dly * 40503) ^ (wr << 17) ^ (bt << 5) ^ (rel << 9) ^ 18'h1_0A0);
            run_xfer(wr[0], bt[0], a, 16'(a * 7 + 3), dly, rel, 1'b0);
          end
    run_xfer(1'b1, 1'b0, 18'h3_0F0F, 16'hC001, 3, 1, 1'b1);
    run_xfer(1'b0, 1'b1, 18'h0_5A5A, 16'h0, 2, 0, 1'b1);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule